// File: doc/BRIEF.md
# SCSI Transfer Error Monitor

This block sits beside the synchronous data path of a parallel SCSI controller and watches two things: the REQ/ACK handshake on the bus and the strobes and flags of the data FIFO. It keeps a count of outstanding offset, which is the number of REQ pulses that no ACK has answered yet. From that count, the bus phase and the FIFO activity it raises sticky status bits.

The role input selects which conditions apply. As an initiator, the block reports a REQ whose sampled phase differs from the expected phase, an offset overflow against the programmed maximum, and a phase change while offset is still outstanding. As a target, the same status bit reports that the initiator has asserted ATN, and an ACK that arrives before any REQ is an offset underflow. FIFO underflow and overflow are reported in either role.

Software or a sequencer reads the bits and clears them with a single-cycle clear pulse. REQ and ACK arrive as single-cycle pulses that are already synchronous to the clock.

Top module: `xfer_err_mon`

## Requirements
- R1: The offset count (`offset_cnt_o`) goes up by one on a cycle with `req_i` and no `ack_i`, and down by one on a cycle with `ack_i` and no `req_i`. It is unchanged when both or neither are high. It saturates at 16 and at 0. It is updated at the clock edge that samples the pulse.
- R2: A cycle with `fifo_rd_i` and `fifo_empty_i` both high sets `gross_cause_o[0]` (data underflow).
- R3: A cycle with `fifo_wr_i` and `fifo_full_i` both high sets `gross_cause_o[1]` (data overflow).
- R4: With `role_i`=1 (target), an `ack_i` without `req_i` while the offset count is 0 sets `gross_cause_o[2]` (offset underflow). With `role_i`=0 (initiator) the same stimulus sets no bit.
- R5: With `role_i`=0, a `req_i` without `ack_i` while the count is already at or above a nonzero `max_ofs_i` sets `gross_cause_o[3]` (offset overflow). A `max_ofs_i` of 0 disables this check, and target role never sets this bit.
- R6: With `role_i`=0, a change of `bus_phase_i` from its value in the previous cycle while the offset count is nonzero sets `gross_cause_o[4]`. A change while the count is zero sets nothing.
- R7: With `role_i`=0, a `req_i` cycle in which `bus_phase_i` differs from `exp_phase_i` sets `mismatch_atn_o`. When the two phases are equal, the bit is not set.
- R8: With `role_i`=1, any cycle with `atn_i` high sets `mismatch_atn_o`. With `role_i`=0, `atn_i` has no effect, and a phase mismatch at REQ has no effect in target role.
- R9: `gross_err_o` is high exactly when at least one bit of `gross_cause_o` is set.
- R10: Every status bit stays set until a cycle with `clr_i` high. A clear in the same cycle as a new setting event leaves that bit set. A clear does not change the offset count.
- R11: A synchronous active-high `rst` clears the offset count and every status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_i | input | 1 | 0 = initiator, 1 = target |
| req_i | input | 1 | REQ pulse, one cycle |
| ack_i | input | 1 | ACK pulse, one cycle |
| bus_phase_i | input | 3 | Phase sampled from the bus |
| exp_phase_i | input | 3 | Expected phase from the output-control latch |
| max_ofs_i | input | 4 | Maximum synchronous offset, 0 = asynchronous |
| atn_i | input | 1 | ATN level seen from the initiator |
| fifo_full_i | input | 1 | Data FIFO full flag |
| fifo_empty_i | input | 1 | Data FIFO empty flag |
| fifo_rd_i | input | 1 | Data FIFO read strobe |
| fifo_wr_i | input | 1 | Data FIFO write strobe |
| clr_i | input | 1 | Clear pulse for all status bits |
| mismatch_atn_o | output | 1 | Phase mismatch (initiator) or ATN seen (target), sticky |
| gross_err_o | output | 1 | OR of all gross-error causes |
| gross_cause_o | output | 5 | Sticky causes: 0 data underflow, 1 data overflow, 2 offset underflow, 3 offset overflow, 4 phase change with offset |
| offset_cnt_o | output | 5 | Outstanding REQ/ACK offset |

## Verification
The hardest condition to reach is a phase change while offset is outstanding, because it needs the counter to be held nonzero while the phase input moves. Any other phase change must happen only at zero offset, or it would set the bit by accident. The bench uses ordered pulse sequences for this: it changes the phase only after the matching ACK has brought the count back to zero, and then, on purpose, changes it once between a REQ and its ACK. The offset-overflow threshold is swept over every maximum value with up to 17 REQ pulses, so both saturation and the disabled case at maximum zero are covered.

// File: rtl/xfer_err_pkg.sv
package xfer_err_pkg;

    typedef enum logic {
        ROLE_INITIATOR = 1'b0,
        ROLE_TARGET    = 1'b1
    } role_e;

    localparam int CAUSE_N = 5;

    // Bit order gives the cause index seen on gross_cause_o.
    typedef struct packed {
        logic phase_chg;
        logic ofs_ovf;
        logic ofs_unf;
        logic data_ovf;
        logic data_unf;
    } cause_t;

    // Saturating step of the outstanding offset.
    function automatic int next_offset(input int cur, input logic req,
                                       input logic ack, input int limit);
        int n;
        n = cur;
        if (req && !ack && cur < limit)
            n = cur + 1;
        else if (ack && !req && cur > 0)
            n = cur - 1;
        return n;
    endfunction

    // A further REQ would push offset past the programmed ceiling.
    function automatic logic offset_at_ceiling(input int cur, input int ceiling);
        return (ceiling != 0) && (cur >= ceiling);
    endfunction

endpackage

// File: rtl/xfer_offset_ctr.sv
module xfer_offset_ctr
    import xfer_err_pkg::*;
#(
    parameter int MAXW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_i,
    input  logic            ack_i,
    output logic [MAXW:0]   cnt_o
);
    localparam int LIMIT = 2 ** MAXW;
    localparam int CW    = MAXW + 1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else
            cnt_o <= CW'(next_offset(int'(cnt_o), req_i, ack_i, LIMIT));
    end
endmodule

// File: rtl/xfer_phase_watch.sv
module xfer_phase_watch
    import xfer_err_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  role_e         role_i,
    input  logic          req_i,
    input  logic          atn_i,
    input  logic [PW-1:0] bus_phase_i,
    input  logic [PW-1:0] exp_phase_i,
    output logic          changed_o,
    output logic          mm_ev_o
);
    logic [PW-1:0] prev_phase;

    always_ff @(posedge clk) begin
        if (rst)
            prev_phase <= '0;
        else
            prev_phase <= bus_phase_i;
    end

    assign changed_o = (bus_phase_i != prev_phase);

    // One status bit, two meanings depending on role.
    always_comb begin
        if (role_i == ROLE_INITIATOR)
            mm_ev_o = req_i && (bus_phase_i != exp_phase_i);
        else
            mm_ev_o = atn_i;
    end
endmodule

// File: rtl/xfer_gross_detect.sv
module xfer_gross_detect
    import xfer_err_pkg::*;
#(
    parameter int MAXW = 4
) (
    input  role_e          role_i,
    input  logic           req_i,
    input  logic           ack_i,
    input  logic [MAXW:0]  cnt_i,
    input  logic [MAXW-1:0] max_ofs_i,
    input  logic           phase_changed_i,
    input  logic           fifo_full_i,
    input  logic           fifo_empty_i,
    input  logic           fifo_rd_i,
    input  logic           fifo_wr_i,
    output cause_t         ev_o
);
    logic is_init;
    logic cnt_zero;

    assign is_init  = (role_i == ROLE_INITIATOR);
    assign cnt_zero = (cnt_i == '0);

    always_comb begin
        ev_o           = '0;
        ev_o.data_unf  = fifo_rd_i && fifo_empty_i;
        ev_o.data_ovf  = fifo_wr_i && fifo_full_i;
        ev_o.ofs_unf   = !is_init && ack_i && !req_i && cnt_zero;
        ev_o.ofs_ovf   = is_init && req_i && !ack_i &&
                         offset_at_ceiling(int'(cnt_i), int'(max_ofs_i));
        ev_o.phase_chg = is_init && !cnt_zero && phase_changed_i;
    end
endmodule

// File: rtl/xfer_sticky_bank.sv
module xfer_sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i)
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/xfer_err_mon.sv
module xfer_err_mon
    import xfer_err_pkg::*;
#(
    parameter int MAXW = 4,
    parameter int PW   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             role_i,
    input  logic             req_i,
    input  logic             ack_i,
    input  logic [PW-1:0]    bus_phase_i,
    input  logic [PW-1:0]    exp_phase_i,
    input  logic [MAXW-1:0]  max_ofs_i,
    input  logic             atn_i,
    input  logic             fifo_full_i,
    input  logic             fifo_empty_i,
    input  logic             fifo_rd_i,
    input  logic             fifo_wr_i,
    input  logic             clr_i,
    output logic             mismatch_atn_o,
    output logic             gross_err_o,
    output logic [CAUSE_N-1:0] gross_cause_o,
    output logic [MAXW:0]    offset_cnt_o
);
    localparam int STAT_N = CAUSE_N + 1;

    role_e              role;
    logic [MAXW:0]      cnt;
    logic               phase_changed;
    logic               mm_ev;
    cause_t             ev;
    logic [STAT_N-1:0]  stat_set;
    logic [STAT_N-1:0]  stat_q;

    assign role = role_e'(role_i);

    xfer_offset_ctr #(.MAXW(MAXW)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_i),
        .ack_i (ack_i),
        .cnt_o (cnt)
    );

    xfer_phase_watch #(.PW(PW)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .role_i      (role),
        .req_i       (req_i),
        .atn_i       (atn_i),
        .bus_phase_i (bus_phase_i),
        .exp_phase_i (exp_phase_i),
        .changed_o   (phase_changed),
        .mm_ev_o     (mm_ev)
    );

    xfer_gross_detect #(.MAXW(MAXW)) u_gross (
        .role_i          (role),
        .req_i           (req_i),
        .ack_i           (ack_i),
        .cnt_i           (cnt),
        .max_ofs_i       (max_ofs_i),
        .phase_changed_i (phase_changed),
        .fifo_full_i     (fifo_full_i),
        .fifo_empty_i    (fifo_empty_i),
        .fifo_rd_i       (fifo_rd_i),
        .fifo_wr_i       (fifo_wr_i),
        .ev_o            (ev)
    );

    assign stat_set = {mm_ev, ev};

    xfer_sticky_bank #(.N(STAT_N)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .set_i (stat_set),
        .q_o   (stat_q)
    );

    assign mismatch_atn_o = stat_q[STAT_N-1];
    assign gross_cause_o  = stat_q[CAUSE_N-1:0];
    assign gross_err_o    = |stat_q[CAUSE_N-1:0];
    assign offset_cnt_o   = cnt;
endmodule

// File: rtl/xfer_err_mon_chk.sv
module xfer_err_mon_chk
    import xfer_err_pkg::*;
#(
    parameter int MAXW = 4,
    parameter int PW   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             role_i,
    input logic             req_i,
    input logic             ack_i,
    input logic [PW-1:0]    bus_phase_i,
    input logic [PW-1:0]    exp_phase_i,
    input logic             atn_i,
    input logic             fifo_full_i,
    input logic             fifo_empty_i,
    input logic             fifo_rd_i,
    input logic             fifo_wr_i,
    input logic             clr_i,
    input logic             mismatch_atn_o,
    input logic [CAUSE_N-1:0] gross_cause_o,
    input logic [MAXW:0]    offset_cnt_o
);
    localparam int LIMIT = 2 ** MAXW;

    logic [CAUSE_N:0] stat;
    assign stat = {mismatch_atn_o, gross_cause_o};

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        int'(offset_cnt_o) <= LIMIT);

    assert_cnt_inc_R1: assert property (@(posedge clk) disable iff (rst)
        (req_i && !ack_i && int'(offset_cnt_o) < LIMIT)
        |=> (offset_cnt_o == $past(offset_cnt_o) + 1'b1));

    assert_data_unf_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd_i && fifo_empty_i) |=> gross_cause_o[0]);

    assert_data_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr_i && fifo_full_i) |=> gross_cause_o[1]);

    assert_ofs_unf_R4: assert property (@(posedge clk) disable iff (rst)
        (role_i && ack_i && !req_i && offset_cnt_o == '0) |=> gross_cause_o[2]);

    assert_phase_chg_R6: assert property (@(posedge clk) disable iff (rst)
        (!role_i && offset_cnt_o != '0 && bus_phase_i != $past(bus_phase_i))
        |=> gross_cause_o[4]);

    assert_mismatch_R7: assert property (@(posedge clk) disable iff (rst)
        (!role_i && req_i && bus_phase_i != exp_phase_i) |=> mismatch_atn_o);

    assert_atn_R8: assert property (@(posedge clk) disable iff (rst)
        (role_i && atn_i) |=> mismatch_atn_o);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (($past(stat) & ~stat) == '0));
endmodule

bind xfer_err_mon xfer_err_mon_chk #(.MAXW(MAXW), .PW(PW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .role_i         (role_i),
    .req_i          (req_i),
    .ack_i          (ack_i),
    .bus_phase_i    (bus_phase_i),
    .exp_phase_i    (exp_phase_i),
    .atn_i          (atn_i),
    .fifo_full_i    (fifo_full_i),
    .fifo_empty_i   (fifo_empty_i),
    .fifo_rd_i      (fifo_rd_i),
    .fifo_wr_i      (fifo_wr_i),
    .clr_i          (clr_i),
    .mismatch_atn_o (mismatch_atn_o),
    .gross_cause_o  (gross_cause_o),
    .offset_cnt_o   (offset_cnt_o)
);

// File: tb/xfer_err_mon_bench.sv
module xfer_err_mon_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       role_i, req_i, ack_i, atn_i;
    logic [2:0] bus_phase_i, exp_phase_i;
    logic [3:0] max_ofs_i;
    logic       fifo_full_i, fifo_empty_i, fifo_rd_i, fifo_wr_i, clr_i;
    logic       mismatch_atn_o, gross_err_o;
    logic [4:0] gross_cause_o;
    logic [4:0] offset_cnt_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    xfer_err_mon u_xfer_err_mon (
        .clk(clk), .rst(rst), .role_i(role_i), .req_i(req_i), .ack_i(ack_i),
        .bus_phase_i(bus_phase_i), .exp_phase_i(exp_phase_i),
        .max_ofs_i(max_ofs_i), .atn_i(atn_i),
        .fifo_full_i(fifo_full_i), .fifo_empty_i(fifo_empty_i),
        .fifo_rd_i(fifo_rd_i), .fifo_wr_i(fifo_wr_i), .clr_i(clr_i),
        .mismatch_atn_o(mismatch_atn_o), .gross_err_o(gross_err_o),
        .gross_cause_o(gross_cause_o), .offset_cnt_o(offset_cnt_o)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: capture at posedge, return at the following negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic pulse_req();
        req_i = 1'b1; step(); req_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1; step(); ack_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1; step(); clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; role_i = 1'b0; req_i = 1'b0; ack_i = 1'b0; atn_i = 1'b0;
        bus_phase_i = 3'd0; exp_phase_i = 3'd0; max_ofs_i = 4'd0;
        fifo_full_i = 1'b0; fifo_empty_i = 1'b0; fifo_rd_i = 1'b0;
        fifo_wr_i = 1'b0; clr_i = 1'b0;
        @(negedge clk);
        do_reset();

        // R11: reset state
        check("R11 cnt", offset_cnt_o, 0);
        check("R11 cause", gross_cause_o, 0);
        check("R11 mm", mismatch_atn_o, 0);
        check("R11 gross", gross_err_o, 0);

        // R1/R5: sweep every maximum offset with up to 17 REQs, initiator role
        for (int m = 0; m < 16; m++) begin
            do_reset();
            role_i = 1'b0;
            max_ofs_i = 4'(m);
            for (int k = 1; k <= 17; k++) begin
                pulse_req();
                check("R1 cnt up", offset_cnt_o, (k > 16) ? 16 : k);
                check("R5 ovf", gross_cause_o[3], (m != 0 && k > m) ? 1 : 0);
                check("R9 gross", gross_err_o, (m != 0 && k > m) ? 1 : 0);
            end
            pulse_clr();
            for (int j = 1; j <= 17; j++) begin
                pulse_ack();
                check("R1 cnt down", offset_cnt_o, (16 - j < 0) ? 0 : 16 - j);
            end
            check("R4 initiator ack at zero", gross_cause_o, 0);
        end

        // R1: simultaneous REQ and ACK leave the count unchanged
        do_reset();
        pulse_req();
        req_i = 1'b1; ack_i = 1'b1; step(); req_i = 1'b0; ack_i = 1'b0;
        check("R1 req+ack", offset_cnt_o, 1);
        pulse_ack();

        // R7: every bus/expected phase pair at a REQ, initiator role
        max_ofs_i = 4'd0;
        for (int b = 0; b < 8; b++) begin
            for (int e = 0; e < 8; e++) begin
                bus_phase_i = 3'(b); exp_phase_i = 3'(e);
                pulse_clr();
                pulse_req();
                check("R7 mismatch", mismatch_atn_o, (b != e) ? 1 : 0);
                pulse_ack();
                check("R6 no change flag at zero offset", gross_cause_o[4], 0);
            end
        end

        // R8: ATN ignored as initiator, reported as target
        do_reset();
        bus_phase_i = 3'd0; exp_phase_i = 3'd0;
        atn_i = 1'b1; step(); atn_i = 1'b0;
        check("R8 atn initiator", mismatch_atn_o, 0);
        role_i = 1'b1;
        atn_i = 1'b1; step(); atn_i = 1'b0;
        check("R8 atn target", mismatch_atn_o, 1);
        pulse_clr();
        check("R10 clear", mismatch_atn_o, 0);
        exp_phase_i = 3'd5;
        pulse_req();
        check("R8 target ignores phase mismatch", mismatch_atn_o, 0);
        pulse_ack();
        exp_phase_i = 3'd0;

        // R4: target offset underflow; R5 target never overflows
        do_reset();
        role_i = 1'b1;
        pulse_ack();
        check("R4 target unf", gross_cause_o[2], 1);
        check("R4 cnt stays 0", offset_cnt_o, 0);
        pulse_clr();
        max_ofs_i = 4'd1;
        pulse_req(); pulse_req();
        check("R5 target no ovf", gross_cause_o, 0);
        pulse_ack(); pulse_ack();

        // R6: phase change with outstanding offset
        do_reset();
        role_i = 1'b0; max_ofs_i = 4'd0; bus_phase_i = 3'd2;
        step();
        pulse_req();
        bus_phase_i = 3'd3;
        step();
        check("R6 phase chg", gross_cause_o[4], 1);
        check("R6 gross", gross_err_o, 1);
        pulse_ack();

        // R2/R3: all strobe/flag combinations
        for (int v = 0; v < 16; v++) begin
            do_reset();
            fifo_rd_i = v[0]; fifo_empty_i = v[1];
            fifo_wr_i = v[2]; fifo_full_i = v[3];
            step();
            fifo_rd_i = 1'b0; fifo_wr_i = 1'b0;
            fifo_empty_i = 1'b0; fifo_full_i = 1'b0;
            check("R2 data unf", gross_cause_o[0], (v[0] && v[1]) ? 1 : 0);
            check("R3 data ovf", gross_cause_o[1], (v[2] && v[3]) ? 1 : 0);
        end

        // R10: sticky, clear racing with a new event, clear leaves count
        do_reset();
        fifo_rd_i = 1'b1; fifo_empty_i = 1'b1; step();
        fifo_rd_i = 1'b0; fifo_empty_i = 1'b0;
        repeat (5) step();
        check("R10 sticky", gross_cause_o[0], 1);
        clr_i = 1'b1; fifo_rd_i = 1'b1; fifo_empty_i = 1'b1; step();
        clr_i = 1'b0; fifo_rd_i = 1'b0; fifo_empty_i = 1'b0;
        check("R10 clear with event", gross_cause_o[0], 1);
        pulse_req(); pulse_req();
        pulse_clr();
        check("R10 cleared", gross_cause_o, 0);
        check("R10 cnt kept", offset_cnt_o, 2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule